// File: doc/BRIEF.md
# Expansion Backplane Slot Select Decoder

This block sits on the backplane of a host-independent expansion bus and turns each bus cycle into a per-slot chip select. It watches the 24-bit bus address together with the four byte-lane write strobes and the single read strobe. It pulls exactly one of sixteen active-low select lines low when two conditions hold:

- the address falls in the IO region;
- at least one strobe is active.

In every other case all sixteen lines stay high. Because the backplane does this decode, a card only has to watch its own select line and use the low sixteen address bits to pick a register.

The top four address bits carry the region tag. The next four bits carry the slot number. The low sixteen bits are the register offset inside the 64 KB window of that slot. With the default tag, slot n therefore answers for addresses 0x4n0000 through 0x4nFFFF.

The tag value is a parameter. A second parameter chooses between a purely combinational decoder and a variant that registers its outputs. A cycle that asserts the read strobe and any write lane at the same time is reported on a separate conflict output, and the decode still goes ahead.

Top module: `slot_select_decoder`

## Requirements
- R1: When address bits [23:20] differ from the IO_TAG parameter, all sixteen select outputs are high.
- R2: When the tag matches and a strobe is active, the select output whose index equals address bits [19:16] is low, and every other select output is high.
- R3: When the read strobe is low and all four write lanes are low, all sixteen select outputs are high, whatever the address.
- R4: Any single write lane on its own, or the read strobe on its own, is enough to enable the decode.
- R5: At no time is more than one select output low.
- R6: When the read strobe is high and any write lane is high, strobe_conflict is 1 and the slot decode still takes place. strobe_conflict is 0 for every other strobe combination.
- R7: Address bits [15:0] have no effect on the select outputs, so 0x400000 and 0x40FFFF both select slot 0, and 0x4F0000 and 0x4FFFFF both select slot 15.
- R8: With REGISTERED=1, the outputs show the decode of the inputs sampled at the previous rising clock edge. While rst is high, they show all selects high and strobe_conflict at 0. With REGISTERED=0, the outputs follow the inputs in the same cycle.
- R9: Changing IO_TAG moves the IO region to the new tag value, and the former tag 0x4 then selects nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered variant and for the checks |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 24 | Bus address: tag, slot number, register offset |
| bus_wstrb | input | 4 | Active-high write strobe, one bit per byte lane |
| bus_rstrb | input | 1 | Active-high read strobe |
| slot_sel_n | output | 16 | Active-low select, bit n for slot n |
| strobe_conflict | output | 1 | High when read and write strobes are active together |

## Verification
The bench builds two copies of the decoder.

- The first copy uses the defaults: IO_TAG = 0x4 and REGISTERED = 0. It covers the same-cycle decode across every tag, every slot and eight strobe combinations.
- The second copy uses IO_TAG = 0x9 and REGISTERED = 1. It covers three things: the one-cycle output delay, the reset state of the output register, and the tag parameter itself. Only this copy can show that tag 0x4 stops selecting and that tag 0x9 starts.

Because every region tag is swept, any tag-match bug in the shared logic shows up on one copy or the other.

// File: rtl/slotdec_pkg.sv
package slotdec_pkg;

    // Bus geometry: register window, slot field and region tag, low to high
    parameter int WIN_W  = 16;
    parameter int SLOT_W = 4;
    parameter int TAG_W  = 4;
    parameter int STRB_W = 4;

    localparam int ADDR_W    = WIN_W + SLOT_W + TAG_W;
    localparam int NUM_SLOTS = 1 << SLOT_W;
    localparam int SLOT_LSB  = WIN_W;
    localparam int TAG_LSB   = WIN_W + SLOT_W;

    typedef logic [ADDR_W-1:0]    addr_t;
    typedef logic [TAG_W-1:0]     tag_t;
    typedef logic [SLOT_W-1:0]    slot_t;
    typedef logic [STRB_W-1:0]    wstrb_t;
    typedef logic [NUM_SLOTS-1:0] sel_vec_t;

    // One bus cycle as seen by the backplane
    typedef struct packed {
        addr_t  addr;
        wstrb_t wstrb;
        logic   rd;
    } bus_cycle_t;

    // Result of the region and strobe qualification
    typedef struct packed {
        logic  enable;
        slot_t slot;
        logic  conflict;
    } decode_t;

    function automatic tag_t addr_tag(input addr_t a);
        return a[TAG_LSB +: TAG_W];
    endfunction

    function automatic slot_t addr_slot(input addr_t a);
        return a[SLOT_LSB +: SLOT_W];
    endfunction

    function automatic logic any_strobe(input bus_cycle_t c);
        return c.rd | (|c.wstrb);
    endfunction

    function automatic logic both_strobes(input bus_cycle_t c);
        return c.rd & (|c.wstrb);
    endfunction

endpackage

// File: rtl/slot_region_gate.sv
module slot_region_gate
    import slotdec_pkg::*;
#(
    parameter tag_t IO_TAG = tag_t'(4'h4)
) (
    input  bus_cycle_t cyc,
    output decode_t    dec
);

    logic tag_hit;
    logic strobe_on;

    always_comb begin
        tag_hit      = (addr_tag(cyc.addr) == IO_TAG);
        strobe_on    = any_strobe(cyc);
        dec.enable   = tag_hit & strobe_on;
        dec.slot     = addr_slot(cyc.addr);
        dec.conflict = both_strobes(cyc);
    end

endmodule

// File: rtl/slot_line_decoder.sv
module slot_line_decoder
    import slotdec_pkg::*;
(
    input  decode_t  dec,
    output sel_vec_t sel_n
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_line
        assign sel_n[g] = ~(dec.enable & (dec.slot == slot_t'(g)));
    end

endmodule

// File: rtl/slot_out_stage.sv
module slot_out_stage
    import slotdec_pkg::*;
#(
    parameter bit REGISTERED = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  sel_vec_t sel_n_d,
    input  logic     conflict_d,
    output sel_vec_t sel_n_q,
    output logic     conflict_q
);

    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                sel_n_q    <= '1;
                conflict_q <= 1'b0;
            end else begin
                sel_n_q    <= sel_n_d;
                conflict_q <= conflict_d;
            end
        end

        // R8: reset leaves the registered outputs idle
        p_reset_idle_r8: assert property (@(posedge clk)
            rst |=> (&sel_n_q && !conflict_q));
    end else begin : g_comb
        assign sel_n_q    = sel_n_d;
        assign conflict_q = conflict_d;

        // The combinational variant never touches its clock domain
        logic unused_ok;
        assign unused_ok = clk ^ rst;
    end

endmodule

// File: rtl/slot_select_decoder.sv
module slot_select_decoder
    import slotdec_pkg::*;
#(
    parameter tag_t IO_TAG     = tag_t'(4'h4),
    parameter bit   REGISTERED = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [STRB_W-1:0]    bus_wstrb,
    input  logic                 bus_rstrb,
    output logic [NUM_SLOTS-1:0] slot_sel_n,
    output logic                 strobe_conflict
);

    bus_cycle_t cyc;
    decode_t    dec;
    sel_vec_t   sel_n_raw;

    assign cyc.addr  = bus_addr;
    assign cyc.wstrb = bus_wstrb;
    assign cyc.rd    = bus_rstrb;

    slot_region_gate #(.IO_TAG(IO_TAG)) u_gate (
        .cyc (cyc),
        .dec (dec)
    );

    slot_line_decoder u_lines (
        .dec   (dec),
        .sel_n (sel_n_raw)
    );

    slot_out_stage #(.REGISTERED(REGISTERED)) u_out (
        .clk        (clk),
        .rst        (rst),
        .sel_n_d    (sel_n_raw),
        .conflict_d (dec.conflict),
        .sel_n_q    (slot_sel_n),
        .conflict_q (strobe_conflict)
    );

    // R5: never two cards selected together
    p_one_card_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~slot_sel_n));

    if (REGISTERED) begin : g_chk_reg
        p_tag_gate_r1: assert property (@(posedge clk) disable iff (rst)
            (addr_tag(bus_addr) != IO_TAG) |=> &slot_sel_n);
        p_idle_r3: assert property (@(posedge clk) disable iff (rst)
            (!bus_rstrb && bus_wstrb == '0) |=> &slot_sel_n);
        p_hit_r2: assert property (@(posedge clk) disable iff (rst)
            (addr_tag(bus_addr) == IO_TAG && (bus_rstrb || |bus_wstrb))
            |=> !slot_sel_n[$past(addr_slot(bus_addr))]);
        p_conflict_r6: assert property (@(posedge clk) disable iff (rst)
            (addr_tag(bus_addr) == IO_TAG && bus_rstrb && |bus_wstrb)
            |=> (strobe_conflict && !(&slot_sel_n)));
    end else begin : g_chk_comb
        p_tag_gate_r1: assert property (@(posedge clk) disable iff (rst)
            (addr_tag(bus_addr) != IO_TAG) |-> &slot_sel_n);
        p_idle_r3: assert property (@(posedge clk) disable iff (rst)
            (!bus_rstrb && bus_wstrb == '0) |-> &slot_sel_n);
        p_hit_r2: assert property (@(posedge clk) disable iff (rst)
            (addr_tag(bus_addr) == IO_TAG && (bus_rstrb || |bus_wstrb))
            |-> !slot_sel_n[addr_slot(bus_addr)]);
        p_conflict_r6: assert property (@(posedge clk) disable iff (rst)
            (addr_tag(bus_addr) == IO_TAG && bus_rstrb && |bus_wstrb)
            |-> (strobe_conflict && !(&slot_sel_n)));
    end

endmodule

// File: tb/slot_select_decoder_tb_top.sv
module slot_select_decoder_tb_top;

    typedef struct {
        logic [15:0] sel;
        logic        conf;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] addr = '0;
    logic [3:0]  wstrb = '0;
    logic        rstrb = 1'b0;

    logic [15:0] sel_c, sel_r;
    logic        conf_c, conf_r;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    slot_select_decoder dut_i (
        .clk (clk), .rst (rst), .bus_addr (addr), .bus_wstrb (wstrb),
        .bus_rstrb (rstrb), .slot_sel_n (sel_c), .strobe_conflict (conf_c)
    );

    slot_select_decoder #(.IO_TAG(4'h9), .REGISTERED(1'b1)) dut_r_i (
        .clk (clk), .rst (rst), .bus_addr (addr), .bus_wstrb (wstrb),
        .bus_rstrb (rstrb), .slot_sel_n (sel_r), .strobe_conflict (conf_r)
    );

    // Reference model written from the requirements
    function automatic logic [15:0] model_sel(input logic [23:0] a, input logic [3:0] w,
                                              input logic r, input logic [3:0] tag);
        logic [15:0] s;
        s = 16'hFFFF;
        if (a[23:20] == tag && (r || w != 4'h0))
            s[a[19:16]] = 1'b0;
        return s;
    endfunction

    task automatic check_sel(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: select actual %h expected %h (addr %h w %h r %b)",
                     req, act, exp, addr, wstrb, rstrb);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: flag actual %b expected %b (addr %h w %h r %b)",
                     req, act, exp, addr, wstrb, rstrb);
        end
    endtask

    // Driver: applies one cycle, checks the same-cycle copy, queues the registered copy
    task automatic drive(input logic [23:0] a, input logic [3:0] w, input logic r, input string req);
        exp_t e;
        @(negedge clk);
        addr = a; wstrb = w; rstrb = r;
        #1;
        check_sel(req, sel_c, model_sel(a, w, r, 4'h4));
        check_bit({req, " R6 conflict"}, conf_c, r && (w != 4'h0));
        check_bit("R5 at most one low", ($countones(~sel_c) <= 1), 1'b1);
        e.sel  = model_sel(a, w, r, 4'h9);
        e.conf = r && (w != 4'h0);
        e.req  = {req, " R8 R9 registered tag 9"};
        exp_q.push_back(e);
    endtask

    // Monitor: registered outputs settle after the rising edge that follows each drive
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check_sel(e.req, sel_r, e.sel);
                check_bit(e.req, conf_r, e.conf);
                check_bit("R5 registered at most one low", ($countones(~sel_r) <= 1), 1'b1);
            end
        end
    end

    initial begin
        #(100000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R8: in reset the registered copy idles even with a hit on its tag
        addr = 24'h930000; wstrb = 4'h1; rstrb = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check_sel("R8 reset selects", sel_r, 16'hFFFF);
        check_bit("R8 reset conflict", conf_r, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // Sweep every tag, slot and strobe combination
        for (int t = 0; t < 16; t++) begin
            for (int s = 0; s < 16; s++) begin
                for (int c = 0; c < 8; c++) begin
                    logic [3:0]  w;
                    logic        r;
                    logic [15:0] low;
                    string       req;
                    r = (c == 1) || (c == 7);
                    w = (c >= 2 && c <= 5) ? 4'(1 << (c - 2)) :
                        (c == 6) ? 4'hF : (c == 7) ? 4'h3 : 4'h0;
                    low = 16'((t * 16 + s) * 16'h0123 + c * 16'h0F0F);
                    if (t != 4)       req = "R1 tag mismatch";
                    else if (c == 0)  req = "R3 no strobe";
                    else if (c == 7)  req = "R6 both strobes";
                    else if (c <= 5)  req = "R4 single strobe";
                    else              req = "R2 slot hit";
                    drive({4'(t), 4'(s), low}, w, r, req);
                end
            end
        end

        // R7: register offset bits leave the decode alone at the window edges
        drive(24'h400000, 4'h0, 1'b1, "R7 slot 0 base");
        drive(24'h40FFFF, 4'h8, 1'b0, "R7 slot 0 top");
        drive(24'h4F0000, 4'h0, 1'b1, "R7 slot 15 base");
        drive(24'h4FFFFF, 4'h2, 1'b0, "R7 slot 15 top");
        drive(24'h9FFFFF, 4'h0, 1'b1, "R9 new tag slot 15");
        drive(24'h4A1234, 4'h0, 1'b0, "R3 idle after hit");

        repeat (3) @(posedge clk);
        #3;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule